// File: doc/BRIEF.md
# Age-Ordered Issue Queue with Tag Wakeup

This block is the scheduling window of an out-of-order core. Renamed instructions arrive in bundles of up to `WIDTH`. Each instruction carries a fetch sequence number, a two-bit latency class, a destination tag and two source tags, and each source has a flag that says whether its value already exists. Entries wait in a pool of `IQ_SIZE` slots until both sources are available. Every cycle the queue hands up to `WIDTH` of the ready entries to the execution lanes, the oldest first.

Execution lanes report results ahead of time. A producer in its final execute cycle drives its destination tag on one of `WIDTH*LAT_MAX` broadcast lanes. Every waiting source with that tag counts as available in that same cycle, so a dependent instruction can issue back to back behind its producer.

The dispatch side uses a valid/ready handshake. `disp_ready` is high when the number of free slots, counting the slots being vacated by this cycle's issue, is at least `disp_cnt`. A bundle transfers in the cycle where `disp_valid` and `disp_ready` are both high, and then all of it enters at once. While `disp_ready` is low the sender holds the bundle unchanged. The issue side has no back-pressure, because the execution lanes are fully pipelined and accept an instruction every cycle.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty, `iss_valid` is all zero, and `disp_ready` is high for any `disp_cnt` up to `WIDTH`.
- R2: `disp_ready` equals (free slots + entries issuing this cycle >= `disp_cnt`). When `disp_valid` and `disp_ready` are both high, exactly `disp_cnt` entries enter. Otherwise no entry enters and the occupancy only drops by the number issued.
- R3: An entry is eligible only when both sources are available. A source is available if its stored flag is set or if a broadcast lane carries its tag in the current cycle, and in the second case the entry may issue in that cycle.
- R4: Up to `WIDTH` eligible entries issue per cycle. Lane 0 carries the oldest one, and valid lanes are contiguous from lane 0.
- R5: Age is decided from the `SEQ_W`-bit sequence numbers by their modular difference (a is older than b when a-b, read as a signed `SEQ_W`-bit value, is negative). This holds across wraparound as long as the live entries span less than 2^(SEQ_W-1).
- R6: An entry leaves the queue in the cycle it issues, and its slot can take a dispatched entry in that same cycle.
- R7: A broadcast that arrives in the cycle an entry is dispatched marks the matching incoming sources as available.
- R8: All `WIDTH*LAT_MAX` broadcast lanes act at once, and any lane may wake any number of sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A dispatch bundle is offered |
| disp_ready | output | 1 | The whole offered bundle fits this cycle |
| disp_cnt | input | clog2(WIDTH+1) | Number of instructions in the bundle, lanes 0 upward |
| disp_seq | input | WIDTH*SEQ_W | Per-lane sequence numbers |
| disp_op | input | WIDTH*2 | Per-lane latency class |
| disp_dst | input | WIDTH*TAG_W | Per-lane destination tag |
| disp_src1 | input | WIDTH*TAG_W | Per-lane first source tag |
| disp_rdy1 | input | WIDTH | First source already available or absent |
| disp_src2 | input | WIDTH*TAG_W | Per-lane second source tag |
| disp_rdy2 | input | WIDTH | Second source already available or absent |
| wake_valid | input | WIDTH*LAT_MAX | Broadcast lane active |
| wake_tag | input | WIDTH*LAT_MAX*TAG_W | Broadcast destination tags |
| iss_valid | output | WIDTH | Issue lane carries an instruction |
| iss_seq | output | WIDTH*SEQ_W | Issued sequence numbers |
| iss_op | output | WIDTH*2 | Issued latency classes |
| iss_dst | output | WIDTH*TAG_W | Issued destination tags |

## Verification
The assertions assume the following about the inputs: `disp_cnt` never exceeds `WIDTH`, sequence numbers are unique among live entries and increase in dispatch order, and the live entries never span half the sequence space. The age-order property depends on the last assumption. The stimulus meets these conditions. It assigns sequence numbers from one running counter and advances that counter only on an accepted bundle. It limits bundle sizes to the range 1 to `WIDTH`. When the oldest waiting entry falls too far behind, it stops dispatching and broadcasts every tag until the window drains.

// File: rtl/iq_pkg.sv
package iq_pkg;

  localparam int OP_W = 2;

  // True when sequence number a was assigned before b, modulo 2^w.
  function automatic logic seq_before(input logic [31:0] a, input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] diff;
    diff = (a - b) << (32 - w);
    return diff[31];
  endfunction

endpackage

// File: rtl/iq_wake_match.sv
module iq_wake_match #(
  parameter int TAG_W = 7,
  parameter int NWAKE = 20
) (
  input  logic [TAG_W-1:0]       tag,
  input  logic [NWAKE-1:0]       bc_valid,
  input  logic [NWAKE*TAG_W-1:0] bc_tag,
  output logic                   hit
);
  logic [NWAKE-1:0] lane_hit;

  for (genvar j = 0; j < NWAKE; j++) begin : g_lane
    assign lane_hit[j] = bc_valid[j] && (bc_tag[j*TAG_W +: TAG_W] == tag);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter  int N     = 16,
  parameter  int WIDTH = 4,
  parameter  int SEQ_W = 10,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]           req,
  input  logic [N*SEQ_W-1:0]     seq_flat,
  output logic [N-1:0]           grant,
  output logic [WIDTH-1:0]       lane_vld,
  output logic [WIDTH*IDX_W-1:0] lane_idx
);
  // Pass k picks the oldest requester not taken by passes 0..k-1.
  always_comb begin
    logic [N-1:0]     taken;
    logic             found;
    logic [IDX_W-1:0] best;
    taken    = '0;
    lane_vld = '0;
    lane_idx = '0;
    for (int k = 0; k < WIDTH; k++) begin
      found = 1'b0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
        if (req[i] && !taken[i]) begin
          if (!found || iq_pkg::seq_before(32'(seq_flat[i*SEQ_W +: SEQ_W]),
                                           32'(seq_flat[int'(best)*SEQ_W +: SEQ_W]),
                                           SEQ_W)) begin
            found = 1'b1;
            best  = IDX_W'(i);
          end
        end
      end
      lane_vld[k] = found;
      lane_idx[k*IDX_W +: IDX_W] = best;
      if (found) taken[best] = 1'b1;
    end
    grant = taken;
  end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter  int N     = 16,
  parameter  int WIDTH = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int AV_W  = $clog2(N + 1)
) (
  input  logic [N-1:0]           avail,
  output logic [WIDTH-1:0]       slot_vld,
  output logic [WIDTH*IDX_W-1:0] slot_idx,
  output logic [AV_W-1:0]        n_avail
);
  // Lane k of a bundle goes to the k-th free slot from the bottom.
  always_comb begin
    logic [N-1:0]     used;
    logic             found;
    logic [IDX_W-1:0] pick;
    used     = '0;
    slot_vld = '0;
    slot_idx = '0;
    for (int k = 0; k < WIDTH; k++) begin
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < N; i++) begin
        if (avail[i] && !used[i] && !found) begin
          found = 1'b1;
          pick  = IDX_W'(i);
        end
      end
      slot_vld[k] = found;
      slot_idx[k*IDX_W +: IDX_W] = pick;
      if (found) used[pick] = 1'b1;
    end
    n_avail = AV_W'($countones(avail));
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter  int IQ_SIZE = 16,
  parameter  int WIDTH   = 4,
  parameter  int TAG_W   = 7,
  parameter  int SEQ_W   = 10,
  parameter  int LAT_MAX = 5,
  localparam int NWAKE   = WIDTH * LAT_MAX,
  localparam int BCNT_W  = $clog2(WIDTH + 1),
  localparam int OP_W    = iq_pkg::OP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [BCNT_W-1:0]        disp_cnt,
  input  logic [WIDTH*SEQ_W-1:0]   disp_seq,
  input  logic [WIDTH*OP_W-1:0]    disp_op,
  input  logic [WIDTH*TAG_W-1:0]   disp_dst,
  input  logic [WIDTH*TAG_W-1:0]   disp_src1,
  input  logic [WIDTH-1:0]         disp_rdy1,
  input  logic [WIDTH*TAG_W-1:0]   disp_src2,
  input  logic [WIDTH-1:0]         disp_rdy2,
  input  logic [NWAKE-1:0]         wake_valid,
  input  logic [NWAKE*TAG_W-1:0]   wake_tag,
  output logic [WIDTH-1:0]         iss_valid,
  output logic [WIDTH*SEQ_W-1:0]   iss_seq,
  output logic [WIDTH*OP_W-1:0]    iss_op,
  output logic [WIDTH*TAG_W-1:0]   iss_dst
);
  localparam int IDX_W = (IQ_SIZE > 1) ? $clog2(IQ_SIZE) : 1;
  localparam int AV_W  = $clog2(IQ_SIZE + 1);

  // Entry storage
  logic [IQ_SIZE-1:0] e_vld, e_r1, e_r2;
  logic [SEQ_W-1:0]   e_seq [IQ_SIZE];
  logic [OP_W-1:0]    e_op  [IQ_SIZE];
  logic [TAG_W-1:0]   e_dst [IQ_SIZE];
  logic [TAG_W-1:0]   e_s1  [IQ_SIZE];
  logic [TAG_W-1:0]   e_s2  [IQ_SIZE];

  logic [IQ_SIZE-1:0]       h1, h2, eligible, grant, avail;
  logic [IQ_SIZE*SEQ_W-1:0] seq_flat;
  logic [WIDTH-1:0]         dh1, dh2, lane_vld, slot_vld;
  logic [WIDTH*IDX_W-1:0]   lane_idx, slot_idx;
  logic [AV_W-1:0]          n_avail;
  logic                     fire;

  // Wakeup match for stored entries
  for (genvar i = 0; i < IQ_SIZE; i++) begin : g_ent
    iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_m1 (
      .tag(e_s1[i]), .bc_valid(wake_valid), .bc_tag(wake_tag), .hit(h1[i]));
    iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_m2 (
      .tag(e_s2[i]), .bc_valid(wake_valid), .bc_tag(wake_tag), .hit(h2[i]));
    assign seq_flat[i*SEQ_W +: SEQ_W] = e_seq[i];
  end

  // Wakeup match for the incoming bundle
  for (genvar k = 0; k < WIDTH; k++) begin : g_din
    iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_d1 (
      .tag(disp_src1[k*TAG_W +: TAG_W]), .bc_valid(wake_valid), .bc_tag(wake_tag),
      .hit(dh1[k]));
    iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_d2 (
      .tag(disp_src2[k*TAG_W +: TAG_W]), .bc_valid(wake_valid), .bc_tag(wake_tag),
      .hit(dh2[k]));
  end

  assign eligible = e_vld & (e_r1 | h1) & (e_r2 | h2);

  iq_select #(.N(IQ_SIZE), .WIDTH(WIDTH), .SEQ_W(SEQ_W)) u_sel (
    .req(eligible), .seq_flat(seq_flat), .grant(grant),
    .lane_vld(lane_vld), .lane_idx(lane_idx));

  assign avail = ~e_vld | grant;

  iq_alloc #(.N(IQ_SIZE), .WIDTH(WIDTH)) u_alloc (
    .avail(avail), .slot_vld(slot_vld), .slot_idx(slot_idx), .n_avail(n_avail));

  assign disp_ready = int'(n_avail) >= int'(disp_cnt);
  assign fire       = disp_valid && disp_ready;

  // Issue lanes
  for (genvar k = 0; k < WIDTH; k++) begin : g_iss
    logic [IDX_W-1:0] src_idx;
    assign src_idx = lane_idx[k*IDX_W +: IDX_W];
    assign iss_valid[k]                = lane_vld[k];
    assign iss_seq[k*SEQ_W +: SEQ_W]   = e_seq[src_idx];
    assign iss_op[k*OP_W +: OP_W]      = e_op[src_idx];
    assign iss_dst[k*TAG_W +: TAG_W]   = e_dst[src_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
    end else begin
      for (int i = 0; i < IQ_SIZE; i++) begin
        if (grant[i]) begin
          e_vld[i] <= 1'b0;
        end else if (e_vld[i]) begin
          if (h1[i]) e_r1[i] <= 1'b1;
          if (h2[i]) e_r2[i] <= 1'b1;
        end
      end
      if (fire) begin
        for (int k = 0; k < WIDTH; k++) begin
          if (k < int'(disp_cnt) && slot_vld[k]) begin
            e_vld[slot_idx[k*IDX_W +: IDX_W]] <= 1'b1;
            e_seq[slot_idx[k*IDX_W +: IDX_W]] <= disp_seq[k*SEQ_W +: SEQ_W];
            e_op [slot_idx[k*IDX_W +: IDX_W]] <= disp_op[k*OP_W +: OP_W];
            e_dst[slot_idx[k*IDX_W +: IDX_W]] <= disp_dst[k*TAG_W +: TAG_W];
            e_s1 [slot_idx[k*IDX_W +: IDX_W]] <= disp_src1[k*TAG_W +: TAG_W];
            e_s2 [slot_idx[k*IDX_W +: IDX_W]] <= disp_src2[k*TAG_W +: TAG_W];
            e_r1 [slot_idx[k*IDX_W +: IDX_W]] <= disp_rdy1[k] | dh1[k];
            e_r2 [slot_idx[k*IDX_W +: IDX_W]] <= disp_rdy2[k] | dh2[k];
          end
        end
      end
    end
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter  int IQ_SIZE = 16,
  parameter  int WIDTH   = 4,
  parameter  int SEQ_W   = 10,
  localparam int BCNT_W  = $clog2(WIDTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [IQ_SIZE-1:0]     occ_vec,
  input logic                   disp_valid,
  input logic                   disp_ready,
  input logic [BCNT_W-1:0]      disp_cnt,
  input logic [WIDTH-1:0]       iss_valid,
  input logic [WIDTH*SEQ_W-1:0] iss_seq
);
  // Rejected bundle: occupancy only drops by what issued (R2)
  assert_reject_no_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && disp_ready) |=>
      $countones(occ_vec) == $past($countones(occ_vec)) - $past($countones(iss_valid)));

  // Accepted bundle: every lane of it enters (R2)
  assert_accept_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=>
      $countones(occ_vec) == $past($countones(occ_vec)) + int'($past(disp_cnt))
                             - $past($countones(iss_valid)));

  // Issue lanes packed from lane 0 (R4)
  assert_lanes_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & (iss_valid + 1'b1)) == '0);

  // Nothing issues out of an empty queue (R6)
  assert_empty_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ_vec == '0 |-> iss_valid == '0);

  // Lower lanes carry strictly older instructions (R5)
  for (genvar k = 0; k + 1 < WIDTH; k++) begin : g_ord
    assert_lane_age_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> iq_pkg::seq_before(32'(iss_seq[k*SEQ_W +: SEQ_W]),
                                            32'(iss_seq[(k+1)*SEQ_W +: SEQ_W]), SEQ_W));
  end
endmodule

bind issue_queue iq_checker #(.IQ_SIZE(IQ_SIZE), .WIDTH(WIDTH), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ_vec(e_vld), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_cnt(disp_cnt), .iss_valid(iss_valid), .iss_seq(iss_seq));

// File: tb/issue_queue_tb.sv
module issue_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IQ  = 4;
  localparam int W   = 2;
  localparam int TW  = 3;
  localparam int SW  = 5;
  localparam int LM  = 5;
  localparam int NW  = W * LM;
  localparam int CW  = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Driven (applied) input state
  logic          a_valid = 1'b0;
  int            a_cnt = 0;
  int            a_base = 0;
  int            a_op[W], a_dst[W], a_s1[W], a_s2[W];
  logic          a_r1[W], a_r2[W];
  logic          a_wv[NW];
  int            a_wt[NW];

  // Staging set by scenario code
  logic          s_valid;
  int            s_cnt;
  int            s_op[W], s_s1[W], s_s2[W];
  logic          s_r1[W], s_r2[W];
  logic          s_wv[NW];
  int            s_wt[NW];

  logic [CW-1:0]       p_cnt;
  logic [W*SW-1:0]     p_seq;
  logic [W*2-1:0]      p_op;
  logic [W*TW-1:0]     p_dst, p_s1, p_s2;
  logic [W-1:0]        p_r1, p_r2;
  logic [NW-1:0]       p_wv;
  logic [NW*TW-1:0]    p_wt;
  logic                disp_ready;
  logic [W-1:0]        iss_valid;
  logic [W*SW-1:0]     iss_seq;
  logic [W*2-1:0]      iss_op;
  logic [W*TW-1:0]     iss_dst;

  always_comb begin
    p_cnt = CW'(a_cnt);
    for (int k = 0; k < W; k++) begin
      p_seq[k*SW +: SW] = SW'(a_base + k);
      p_op[k*2 +: 2]    = 2'(a_op[k]);
      p_dst[k*TW +: TW] = TW'(a_dst[k]);
      p_s1[k*TW +: TW]  = TW'(a_s1[k]);
      p_s2[k*TW +: TW]  = TW'(a_s2[k]);
      p_r1[k] = a_r1[k];
      p_r2[k] = a_r2[k];
    end
    for (int j = 0; j < NW; j++) begin
      p_wv[j] = a_wv[j];
      p_wt[j*TW +: TW] = TW'(a_wt[j]);
    end
  end

  issue_queue #(.IQ_SIZE(IQ), .WIDTH(W), .TAG_W(TW), .SEQ_W(SW), .LAT_MAX(LM)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(a_valid), .disp_ready(disp_ready),
    .disp_cnt(p_cnt), .disp_seq(p_seq), .disp_op(p_op), .disp_dst(p_dst),
    .disp_src1(p_s1), .disp_rdy1(p_r1), .disp_src2(p_s2), .disp_rdy2(p_r2),
    .wake_valid(p_wv), .wake_tag(p_wt), .iss_valid(iss_valid), .iss_seq(iss_seq),
    .iss_op(iss_op), .iss_dst(iss_dst));

  // Reference model: a list of waiting instructions with unbounded ages
  typedef struct { int seq; int op; int dst; int s1; logic r1; int s2; logic r2; } ment_t;
  ment_t mq[$];
  int    gseq = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic bit woken(int t);
    for (int j = 0; j < NW; j++) if (a_wv[j] && a_wt[j] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
    end
  endtask

  task automatic clear_stage();
    s_valid = 1'b0; s_cnt = 0;
    for (int k = 0; k < W; k++) begin
      s_op[k] = 0; s_s1[k] = 0; s_s2[k] = 0; s_r1[k] = 1'b1; s_r2[k] = 1'b1;
    end
    for (int j = 0; j < NW; j++) begin s_wv[j] = 1'b0; s_wt[j] = 0; end
  endtask

  task automatic step();
    int  pick[$];
    bit  taken[$];
    int  best;
    bit  exp_rdy;
    @(negedge clk);
    a_valid = s_valid; a_cnt = s_cnt; a_base = gseq;
    for (int k = 0; k < W; k++) begin
      a_op[k] = s_op[k]; a_dst[k] = (gseq + k) % 8;
      a_s1[k] = s_s1[k]; a_s2[k] = s_s2[k]; a_r1[k] = s_r1[k]; a_r2[k] = s_r2[k];
    end
    for (int j = 0; j < NW; j++) begin a_wv[j] = s_wv[j]; a_wt[j] = s_wt[j]; end
    #1;
    // expected issue set: oldest eligible first
    taken = {};
    foreach (mq[i]) taken.push_back(1'b0);
    for (int k = 0; k < W; k++) begin
      best = -1;
      foreach (mq[i])
        if (!taken[i] && (mq[i].r1 || woken(mq[i].s1)) && (mq[i].r2 || woken(mq[i].s2)))
          if (best < 0 || mq[i].seq < mq[best].seq) best = i;
      if (best >= 0) begin taken[best] = 1'b1; pick.push_back(best); end
    end
    for (int k = 0; k < W; k++) begin
      chk(iss_valid[k] == (k < pick.size()), $sformatf("lane %0d valid", k),
          int'(iss_valid[k]), int'(k < pick.size()));
      if (k < pick.size() && iss_valid[k]) begin
        chk(int'(iss_seq[k*SW +: SW]) == mq[pick[k]].seq % 32, $sformatf("lane %0d seq", k),
            int'(iss_seq[k*SW +: SW]), mq[pick[k]].seq % 32);
        chk(int'(iss_op[k*2 +: 2]) == mq[pick[k]].op, $sformatf("lane %0d op", k),
            int'(iss_op[k*2 +: 2]), mq[pick[k]].op);
        chk(int'(iss_dst[k*TW +: TW]) == mq[pick[k]].dst, $sformatf("lane %0d dst", k),
            int'(iss_dst[k*TW +: TW]), mq[pick[k]].dst);
      end
    end
    exp_rdy = (IQ - mq.size() + pick.size()) >= a_cnt;
    chk(disp_ready == exp_rdy, "disp_ready", int'(disp_ready), int'(exp_rdy));
    // advance model
    for (int i = mq.size() - 1; i >= 0; i--) if (taken[i]) mq.delete(i);
    foreach (mq[i]) begin
      if (woken(mq[i].s1)) mq[i].r1 = 1'b1;
      if (woken(mq[i].s2)) mq[i].r2 = 1'b1;
    end
    if (a_valid && exp_rdy) begin
      for (int k = 0; k < a_cnt; k++) begin
        ment_t e;
        e.seq = gseq + k; e.op = a_op[k]; e.dst = a_dst[k];
        e.s1 = a_s1[k]; e.s2 = a_s2[k];
        e.r1 = a_r1[k] | woken(a_s1[k]);
        e.r2 = a_r2[k] | woken(a_s2[k]);
        mq.push_back(e);
      end
      gseq += a_cnt;
    end
  endtask

  task automatic drain();
    clear_stage();
    for (int j = 0; j < 8; j++) begin s_wv[j] = 1'b1; s_wt[j] = j; end
    for (int c = 0; c < 4; c++) step();
    clear_stage();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired while checking %s", cur_req);
      finish_run();
    end
  end

  initial begin
    foreach (a_op[k]) begin
      a_op[k] = 0; a_dst[k] = 0; a_s1[k] = 0; a_s2[k] = 0; a_r1[k] = 1'b1; a_r2[k] = 1'b1;
    end
    foreach (a_wv[j]) begin a_wv[j] = 1'b0; a_wt[j] = 0; end
    clear_stage();
    repeat (3) @(negedge clk);
    // R1: quiet outputs while reset is held
    chk(iss_valid == '0, "iss_valid in reset", int'(iss_valid), 0);
    rst_n = 1'b1;
    // R1: empty after reset, accepts a full bundle
    cur_req = "R1";
    s_cnt = W;
    step();

    // R3: dependent waits, then issues in the cycle its producer broadcasts
    cur_req = "R3";
    clear_stage();
    s_valid = 1'b1; s_cnt = 2;
    s_s1[0] = 1; s_r1[0] = 1'b0; s_op[0] = 2;
    s_s2[1] = 2; s_r2[1] = 1'b0; s_op[1] = 1;
    step();
    clear_stage();
    step();
    s_wv[3] = 1'b1; s_wt[3] = 1;
    step();
    clear_stage();
    s_wv[0] = 1'b1; s_wt[0] = 2;
    step();
    clear_stage();
    step();

    // R7: broadcast in the dispatch cycle is kept by the new entry
    cur_req = "R7";
    s_valid = 1'b1; s_cnt = 1; s_s1[0] = 3; s_r1[0] = 1'b0;
    s_wv[9] = 1'b1; s_wt[9] = 3;
    step();
    clear_stage();
    step();
    step();

    // R2: fill with blocked entries, then a bundle must be refused whole
    cur_req = "R2";
    drain();
    cur_req = "R2";
    s_valid = 1'b1; s_cnt = 2;
    s_s1[0] = 4; s_r1[0] = 1'b0; s_s1[1] = 5; s_r1[1] = 1'b0;
    step();
    s_s1[0] = 6; s_s1[1] = 7;
    step();
    s_s1[0] = 1; s_s1[1] = 2; s_cnt = 1;
    step();
    step();

    // R6: one entry issues and its slot takes a new entry in the same cycle
    cur_req = "R6";
    s_cnt = 1; s_s1[0] = 1; s_r1[0] = 1'b0;
    s_wv[5] = 1'b1; s_wt[5] = 4;
    step();
    clear_stage();
    s_valid = 1'b1; s_cnt = 2;
    s_wv[2] = 1'b1; s_wt[2] = 5;
    step();
    clear_stage();
    step();

    // R8: many lanes at once, duplicates included
    cur_req = "R8";
    for (int j = 0; j < NW; j++) begin s_wv[j] = 1'b1; s_wt[j] = j % 8; end
    step();
    step();
    step();
    drain();

    // R4 R5: random traffic; the 5-bit sequence wraps many times
    cur_req = "R4 R5";
    for (int c = 0; c < 600; c++) begin
      int oldest;
      clear_stage();
      oldest = gseq;
      foreach (mq[i]) if (mq[i].seq < oldest) oldest = mq[i].seq;
      if (gseq - oldest >= 12) begin
        for (int j = 0; j < 8; j++) begin s_wv[j] = 1'b1; s_wt[j] = j; end
      end else begin
        s_valid = ($urandom_range(0, 3) != 0);
        s_cnt = $urandom_range(1, W);
        for (int k = 0; k < W; k++) begin
          s_op[k] = $urandom_range(0, 2);
          s_s1[k] = $urandom_range(0, 7); s_r1[k] = $urandom_range(0, 1);
          s_s2[k] = $urandom_range(0, 7); s_r2[k] = $urandom_range(0, 1);
        end
        for (int j = 0; j < NW; j++) begin
          s_wv[j] = ($urandom_range(0, 9) < 2);
          s_wt[j] = $urandom_range(0, 7);
        end
      end
      step();
    end
    drain();
    finish_run();
  end
endmodule